// File: doc/BRIEF.md
# Flash Host Bus Command Front End

This block sits between an asynchronous parallel flash bus and the internal logic of a flash memory model. It samples the active-low chip-enable, output-enable and write-enable strobes on a fast internal clock and passes each one through a two-stage synchroniser. It then ignores any level that has not held for a programmable number of consecutive samples, so short noise pulses never reach the command logic.

A write cycle is a window in which the filtered strobes show chip and write enable both low and output enable high. The address is captured when the window opens. The data is captured when the window closes because chip enable or write enable went high. Each completed write drives a command sequencer. That sequencer checks the multi-write unlock patterns and issues one-cycle requests to the program/erase controller: program, sector erase, chip erase, erase suspend and erase resume.

On reads, the block selects what appears on the data pins: array data, controller status while the controller is busy, or identification codes and per-sector protection flags. A strap picks 16-bit output or 8-bit output. In 8-bit output the top data pin becomes the least-significant byte-address input.

Top module: `flash_host_if`

## Requirements
- R1: A write is taken only while filtered chip enable and write enable are low and output enable is high; a cycle with all three strobes low has no effect on the command state.
- R2: The write address is the value present when the later of chip enable and write enable falls, so an address change before that point is used and one after it is ignored.
- R3: The write data is the value present when the earlier of chip enable and write enable rises; data changes after that rise are ignored.
- R4: A low pulse on a strobe that lasts fewer than FILT_N clock samples does not register as a write.
- R5: Writes of AAh to word 555h, 55h to word 2AAh and A0h, followed by one more write, issue a program request (kind code 1) carrying that write's address and data.
- R6: After the two unlock writes, the sequence 80h, AAh@555h, 55h@2AAh issues a sector-erase request (kind 2) when followed by 30h at any address, or a chip-erase request (kind 3) when followed by 10h@555h.
- R7: A write that departs from an unlock pattern, or F0h at any step, returns the sequencer to read mode, and no request follows.
- R8: In read mode, a single write of B0h issues a suspend request (kind 4) and a single write of 30h issues a resume request (kind 5); every request is a one-cycle pulse.
- R9: With chip enable and output enable low and write enable high, the pins are driven with array data at the current word address; with output enable high, all pins are released (output enable vector 0).
- R10: With byte_mode low, only pins 7:0 are driven (output enable vector 00FFh); pin 15 input value 0 selects the low byte and 1 selects the high byte of the array word, and the byte address sent with a request ends in that bit.
- R11: After the unlock pair and 90h, reads return 52h at word offset 00h, the device code at offset 01h, and at offset 02h bit 0 set to the protection flag of the sector named by the top SECT_W address bits; F0h restores array reads.
- R12: While the controller signals busy, reads return the controller status byte in place of array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| byte_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| addr | input | ADDR_W | Word address from the bus |
| dq_in | input | 16 | Data pins as inputs; bit 15 is the byte-address bit in 8-bit mode |
| dq_out | output | 16 | Data driven toward the pins |
| dq_oe | output | 16 | Per-pin output enable |
| arr_addr | output | ADDR_W | Word address toward the array |
| arr_rdata | input | 16 | Array read word |
| ctl_busy | input | 1 | Program/erase controller busy |
| ctl_status | input | 8 | Controller status byte |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request code: 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| req_addr | output | ADDR_W+1 | Byte address of the request write |
| req_data | output | 16 | Data of the request write |

## Verification
The checks assume that address and data inputs stay stable from the raw strobe edge until the filtered edge arrives, which is the synchroniser depth plus FILT_N cycles. They also assume that byte_mode and the sector protection flags change only between bus cycles. The stimulus changes every bus input on the falling clock edge. It holds each strobe level for twelve cycles, well past the filter latency, except in the deliberate short-pulse case. Address and data changes inside a write window are placed at least twelve cycles away from either filtered window edge.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

    typedef enum logic [2:0] {
        RQ_NONE   = 3'd0,
        RQ_PROG   = 3'd1,
        RQ_SERASE = 3'd2,
        RQ_CERASE = 3'd3,
        RQ_SUSP   = 3'd4,
        RQ_RESUME = 3'd5
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_READ, ST_ID, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS0, ST_ERS1, ST_ERS2
    } cmd_state_t;

    // filtered strobe levels, all active low
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
    } bus_ctl_t;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_PROG    = 8'hA0;
    localparam logic [7:0]  OP_IDENT   = 8'h90;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_SECTOR  = 8'h30;
    localparam logic [7:0]  OP_CHIP    = 8'h10;
    localparam logic [7:0]  OP_SUSP    = 8'hB0;
    localparam logic [7:0]  OP_RESUME  = 8'h30;
    localparam logic [7:0]  MAKER_CODE = 8'h52;

    function automatic logic is_write(bus_ctl_t c);
        return !c.ce && !c.we && c.oe;
    endfunction

    function automatic logic is_read(bus_ctl_t c);
        return !c.ce && !c.oe && c.we;
    endfunction

    function automatic logic key_hit(logic [10:0] a, logic [7:0] d,
                                     logic [10:0] ea, logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fbi_filter.sv
module fbi_filter #(
    parameter int FILT_N = 3,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_N + 1);

    logic [SYNC_N-1:0] sy;
    logic [CNT_W-1:0]  cnt;
    logic              smp;

    assign smp = sy[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= '1;
            cnt  <= '0;
            dout <= 1'b1;
        end else begin
            sy <= {sy[SYNC_N-2:0], din};
            if (smp == dout) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_N - 1)) begin
                cnt  <= '0;
                dout <= smp;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    filt_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(smp) == dout));

endmodule

// File: rtl/fbi_cycle.sv
module fbi_cycle
    import fbi_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ctl_t          ctl,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic              wr_stb,
    output logic [ADDR_W:0]   wr_addr,
    output logic [15:0]       wr_data
);
    logic win, win_q, opening, closing;

    assign win     = is_write(ctl);
    assign opening = win && !win_q;
    assign closing = win_q && !win && (ctl.ce || ctl.we);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            win_q  <= win;
            wr_stb <= closing;
            if (opening)
                wr_addr <= {addr, byte_mode ? 1'b0 : dq_in[15]};
            if (closing)
                wr_data <= byte_mode ? dq_in : {8'h00, dq_in[7:0]};
        end
    end

    // R1
    wr_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(ctl.oe, 2));

    // R3
    wr_close_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(ctl.ce) || $past(ctl.we)));

endmodule

// File: rtl/fbi_cmd.sv
module fbi_cmd
    import fbi_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W:0]   wr_addr,
    input  logic [15:0]       wr_data,
    output logic              req_valid,
    output req_kind_t         req_kind,
    output logic [ADDR_W:0]   req_addr,
    output logic [15:0]       req_data,
    output logic              id_mode
);
    cmd_state_t  state, nxt;
    logic        fire;
    req_kind_t   fkind;
    logic [10:0] wa;
    logic [7:0]  cb;

    assign wa      = wr_addr[11:1];
    assign cb      = wr_data[7:0];
    assign id_mode = (state == ST_ID);

    always_comb begin
        nxt   = ST_READ;
        fire  = 1'b0;
        fkind = RQ_NONE;
        unique case (state)
            ST_READ: begin
                if (key_hit(wa, cb, KEY_ADDR_A, KEY_A)) nxt = ST_UNL1;
                else if (cb == OP_SUSP)   begin fire = 1'b1; fkind = RQ_SUSP;   end
                else if (cb == OP_RESUME) begin fire = 1'b1; fkind = RQ_RESUME; end
            end
            ST_ID: begin
                if (key_hit(wa, cb, KEY_ADDR_A, KEY_A)) nxt = ST_UNL1;
            end
            ST_UNL1: begin
                if (key_hit(wa, cb, KEY_ADDR_B, KEY_B)) nxt = ST_UNL2;
            end
            ST_UNL2: begin
                if (cb == OP_PROG)       nxt = ST_PROG;
                else if (cb == OP_IDENT) nxt = ST_ID;
                else if (cb == OP_ERASE) nxt = ST_ERS0;
            end
            ST_PROG: begin
                fire  = 1'b1;
                fkind = RQ_PROG;
            end
            ST_ERS0: begin
                if (key_hit(wa, cb, KEY_ADDR_A, KEY_A)) nxt = ST_ERS1;
            end
            ST_ERS1: begin
                if (key_hit(wa, cb, KEY_ADDR_B, KEY_B)) nxt = ST_ERS2;
            end
            ST_ERS2: begin
                if (cb == OP_SECTOR) begin
                    fire = 1'b1; fkind = RQ_SERASE;
                end else if (key_hit(wa, cb, KEY_ADDR_A, OP_CHIP)) begin
                    fire = 1'b1; fkind = RQ_CERASE;
                end
            end
            default: nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READ;
            req_valid <= 1'b0;
            req_kind  <= RQ_NONE;
            req_addr  <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= 1'b0;
            if (wr_stb) begin
                state <= nxt;
                if (fire) begin
                    req_valid <= 1'b1;
                    req_kind  <= fkind;
                    req_addr  <= wr_addr;
                    req_data  <= wr_data;
                end
            end
        end
    end

    // R5
    prog_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == RQ_PROG) |-> ($past(state) == ST_PROG && $past(wr_stb)));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R6
    erase_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_kind == RQ_SERASE || req_kind == RQ_CERASE)) |-> ($past(state) == ST_ERS2));

endmodule

// File: rtl/fbi_rdmux.sv
module fbi_rdmux
    import fbi_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          SECT_W   = 4,
    parameter logic [15:0] DEV_CODE = 16'h22DA
) (
    input  bus_ctl_t               ctl,
    input  logic                   byte_mode,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   lane_bit,
    input  logic                   id_mode,
    input  logic                   busy,
    input  logic [7:0]             status,
    input  logic [15:0]            arr_rdata,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    output logic [15:0]            dq_out,
    output logic [15:0]            dq_oe
);
    logic [SECT_W-1:0] sect;
    logic [15:0]       word;
    logic              use_lane;
    logic              rd;

    assign sect = addr[ADDR_W-1 -: SECT_W];
    assign rd   = is_read(ctl);

    always_comb begin
        word     = arr_rdata;
        use_lane = 1'b1;
        if (busy) begin
            word     = {8'h00, status};
            use_lane = 1'b0;
        end else if (id_mode) begin
            use_lane = 1'b0;
            case (addr[7:0])
                8'h00:   word = {8'h00, MAKER_CODE};
                8'h01:   word = DEV_CODE;
                8'h02:   word = {15'd0, sect_prot[sect]};
                default: word = 16'h0000;
            endcase
        end
    end

    always_comb begin
        if (byte_mode) begin
            dq_out = word;
            dq_oe  = rd ? 16'hFFFF : 16'h0000;
        end else begin
            dq_out = {8'h00, (use_lane && lane_bit) ? word[15:8] : word[7:0]};
            dq_oe  = rd ? 16'h00FF : 16'h0000;
        end
    end

endmodule

// File: rtl/flash_host_if.sv
module flash_host_if
    import fbi_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          SECT_W   = 4,
    parameter int          FILT_N   = 3,
    parameter int          SYNC_N   = 2,
    parameter logic [15:0] DEV_CODE = 16'h22DA,
    localparam int         SECT_N   = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [15:0]       arr_rdata,
    input  logic              ctl_busy,
    input  logic [7:0]        ctl_status,
    input  logic [SECT_N-1:0] sect_prot,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [ADDR_W:0]   req_addr,
    output logic [15:0]       req_data
);
    logic [2:0]      raw_strb;
    logic [2:0]      flt_strb;
    bus_ctl_t        ctl;
    logic            wr_stb;
    logic [ADDR_W:0] wr_addr;
    logic [15:0]     wr_data;
    logic            id_mode;
    req_kind_t       kind;

    assign raw_strb = {we_n, oe_n, ce_n};

    for (genvar i = 0; i < 3; i++) begin : g_strb
        fbi_filter #(.FILT_N(FILT_N), .SYNC_N(SYNC_N)) filt_i (
            .clk (clk),
            .rst (rst),
            .din (raw_strb[i]),
            .dout(flt_strb[i])
        );
    end

    assign ctl.ce = flt_strb[0];
    assign ctl.oe = flt_strb[1];
    assign ctl.we = flt_strb[2];

    fbi_cycle #(.ADDR_W(ADDR_W)) cyc_i (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .byte_mode(byte_mode),
        .addr     (addr),
        .dq_in    (dq_in),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    fbi_cmd #(.ADDR_W(ADDR_W)) cmd_i (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .req_valid(req_valid),
        .req_kind (kind),
        .req_addr (req_addr),
        .req_data (req_data),
        .id_mode  (id_mode)
    );

    assign req_kind = kind;
    assign arr_addr = addr;

    fbi_rdmux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DEV_CODE(DEV_CODE)) mux_i (
        .ctl      (ctl),
        .byte_mode(byte_mode),
        .addr     (addr),
        .lane_bit (dq_in[15]),
        .id_mode  (id_mode),
        .busy     (ctl_busy),
        .status   (ctl_status),
        .arr_rdata(arr_rdata),
        .sect_prot(sect_prot),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    // R9
    drive_when_read_chk: assert property (@(posedge clk) disable iff (rst)
        (|dq_oe) |-> (!flt_strb[0] && !flt_strb[1] && flt_strb[2]));

    // R10
    byte_upper_off_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_mode |-> (dq_oe[15:8] == 8'h00));

    // R1
    no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!flt_strb[1]) |=> !wr_stb);

endmodule

// File: tb/flash_host_if_tb_top.sv
`timescale 1ns/1ps
module flash_host_if_tb_top;
    import fbi_pkg::*;

    localparam int ADDR_W = 19;
    localparam int SECT_W = 4;
    localparam int FILT_N = 3;
    localparam int HOLD   = 12;
    localparam logic [15:0] DEV = 16'h22DA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic byte_mode = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe, arr_rdata;
    logic [ADDR_W-1:0] arr_addr;
    logic ctl_busy = 1'b0;
    logic [7:0] ctl_status = 8'h00;
    logic [(1<<SECT_W)-1:0] sect_prot = 16'h0020;
    logic req_valid;
    logic [2:0] req_kind;
    logic [ADDR_W:0] req_addr;
    logic [15:0] req_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign arr_rdata = arr_addr[15:0] ^ 16'hA5C3;

    flash_host_if #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .FILT_N(FILT_N), .DEV_CODE(DEV)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_mode(byte_mode), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .ctl_busy(ctl_busy), .ctl_status(ctl_status), .sect_prot(sect_prot),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data)
    );

    typedef struct {
        logic [2:0]      kind;
        logic [ADDR_W:0] a;
        logic [15:0]     d;
        string           tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic expect_req(logic [2:0] k, logic [ADDR_W:0] a, logic [15:0] d, string tag);
        exp_t e;
        e.kind = k; e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pop expected items as requests appear
    always @(negedge clk) begin
        if (!rst && req_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected request act=%h exp=none", {req_kind, req_addr, req_data});
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {9'd0, req_kind, req_addr}, {9'd0, e.kind, e.a});
                check(e.tag, {16'd0, req_data}, {16'd0, e.d});
            end
        end
    end

    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [15:0] d, logic oe_lvl = 1'b1);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = oe_lvl;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic unlock(logic lsb = 1'b0);
        bus_wr(19'h555, {lsb, 15'h00AA});
        bus_wr(19'h2AA, {lsb, 15'h0055});
    endtask

    task automatic bus_rd(logic [ADDR_W-1:0] a, logic lsb, output logic [15:0] d, output logic [15:0] oe);
        @(negedge clk);
        addr = a; dq_in = {lsb, 15'd0};
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (HOLD) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, o;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset oe", {16'd0, dq_oe}, 32'd0);
        check("R8 reset req", {31'd0, req_valid}, 32'd0);

        // R9 array read and release
        bus_rd(19'h01234, 1'b0, d, o);
        check("R9 read data", {16'd0, d}, {16'd0, 16'h1234 ^ 16'hA5C3});
        check("R9 read oe", {16'd0, o}, 32'h0000FFFF);
        @(negedge clk); addr = 19'h00042; ce_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        check("R9 oe high releases", {16'd0, dq_oe}, 32'd0);
        ce_n = 1'b1; repeat (HOLD) @(negedge clk);

        // R5 program
        unlock();
        bus_wr(19'h555, 16'h00A0);
        expect_req(3'd1, {19'h7ABCD, 1'b0}, 16'h4321, "R5");
        bus_wr(19'h7ABCD, 16'h4321);

        // R6 sector erase then chip erase
        unlock(); bus_wr(19'h555, 16'h0080); unlock();
        expect_req(3'd2, {19'h30000, 1'b0}, 16'h0030, "R6");
        bus_wr(19'h30000, 16'h0030);
        unlock(); bus_wr(19'h555, 16'h0080); unlock();
        expect_req(3'd3, {19'h00555, 1'b0}, 16'h0010, "R6");
        bus_wr(19'h555, 16'h0010);

        // R8 suspend / resume
        expect_req(3'd4, {19'h11111, 1'b0}, 16'h00B0, "R8");
        bus_wr(19'h11111, 16'h00B0);
        expect_req(3'd5, {19'h22222, 1'b0}, 16'h0030, "R8");
        bus_wr(19'h22222, 16'h0030);

        // R7 broken unlock, then F0 mid-sequence: no request may follow
        bus_wr(19'h555, 16'h00AA);
        bus_wr(19'h123, 16'h0055);
        bus_wr(19'h555, 16'h00A0);
        bus_wr(19'h00100, 16'h1111);
        unlock();
        bus_wr(19'h555, 16'h00F0);
        bus_wr(19'h555, 16'h00A0);
        bus_wr(19'h00200, 16'h2222);
        check("R7 no request pending", sb.size(), 32'd0);
        bus_rd(19'h00077, 1'b0, d, o);
        check("R7 back in read mode", {16'd0, d}, {16'd0, 16'h0077 ^ 16'hA5C3});

        // R1 write with OE low is ignored inside a sequence
        bus_wr(19'h555, 16'h00AA);
        bus_wr(19'h00000, 16'h0000, 1'b0);
        bus_wr(19'h2AA, 16'h0055);
        bus_wr(19'h555, 16'h00A0);
        expect_req(3'd1, {19'h00300, 1'b0}, 16'h3333, "R1");
        bus_wr(19'h00300, 16'h3333);

        // R4 short WE pulse is filtered out
        bus_wr(19'h555, 16'h00AA);
        @(negedge clk); addr = 19'h00000; dq_in = 16'h0000; ce_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        we_n = 1'b0;
        repeat (FILT_N - 1) @(negedge clk);
        we_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        ce_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        bus_wr(19'h2AA, 16'h0055);
        bus_wr(19'h555, 16'h00A0);
        expect_req(3'd1, {19'h00400, 1'b0}, 16'h4444, "R4");
        bus_wr(19'h00400, 16'h4444);

        // R2 / R3 address at later fall (WE), data at earlier rise (WE)
        unlock();
        bus_wr(19'h555, 16'h00A0);
        expect_req(3'd1, {19'h05A5A, 1'b0}, 16'hBEEF, "R2 R3");
        @(negedge clk); addr = 19'h01111; dq_in = 16'h0001; ce_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        addr = 19'h05A5A;
        repeat (HOLD) @(negedge clk);
        we_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        addr = 19'h06666; dq_in = 16'hBEEF;
        repeat (HOLD) @(negedge clk);
        we_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        dq_in = 16'hDEAD;
        repeat (HOLD) @(negedge clk);
        ce_n = 1'b1;
        repeat (HOLD) @(negedge clk);

        // R11 identification mode
        unlock();
        bus_wr(19'h555, 16'h0090);
        bus_rd(19'h00000, 1'b0, d, o);
        check("R11 maker", {16'd0, d}, 32'h00000052);
        bus_rd(19'h00001, 1'b0, d, o);
        check("R11 device", {16'd0, d}, {16'd0, DEV});
        bus_rd((19'd5 << 15) | 19'h2, 1'b0, d, o);
        check("R11 protected sector", {16'd0, d}, 32'h00000001);
        bus_rd((19'd4 << 15) | 19'h2, 1'b0, d, o);
        check("R11 open sector", {16'd0, d}, 32'h00000000);
        bus_wr(19'h00000, 16'h00F0);
        bus_rd(19'h00000, 1'b0, d, o);
        check("R11 exit to array", {16'd0, d}, {16'd0, 16'hA5C3});

        // R12 busy routes status
        ctl_busy = 1'b1; ctl_status = 8'h8C;
        bus_rd(19'h00123, 1'b0, d, o);
        check("R12 status", {16'd0, d}, 32'h0000008C);
        ctl_busy = 1'b0;
        bus_rd(19'h00123, 1'b0, d, o);
        check("R12 after busy", {16'd0, d}, {16'd0, 16'h0123 ^ 16'hA5C3});

        // R10 byte mode
        byte_mode = 1'b0;
        repeat (HOLD) @(negedge clk);
        bus_rd(19'h00456, 1'b0, d, o);
        check("R10 low lane", {24'd0, d[7:0]}, {24'd0, 8'hC3 ^ 8'h56});
        check("R10 oe", {16'd0, o}, 32'h000000FF);
        bus_rd(19'h00456, 1'b1, d, o);
        check("R10 high lane", {24'd0, d[7:0]}, {24'd0, 8'hA5 ^ 8'h04});
        unlock(1'b0);
        bus_wr(19'h555, 16'h00A0);
        expect_req(3'd1, {19'h00100, 1'b1}, 16'h005A, "R10");
        bus_wr(19'h00100, 16'h805A);
        byte_mode = 1'b1;

        repeat (20) @(negedge clk);
        check("R5 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule